// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps the pending state of a set of interrupt sources for up to eight target processors. Three kinds of event change that state: the hardware request lines, byte-wide register writes to a set-pending window and a clear-pending window, and acknowledge strobes from a processor. Each source is configured as level-sensitive or edge-triggered. Each source is also configured for one-to-one delivery, where an acknowledge affects only the processor that takes it, or one-of-many delivery, where an acknowledge withdraws the request from every processor.

The block holds a second latch next to each pending bit. This latch records that software marked a level-sensitive source pending. With the latch set, the pending bit survives the hardware line going low. A software clear also cannot remove a level request whose line is still high. The outputs are per-processor pending bitmaps. Arbitration, enables, active state and processor signalling are handled elsewhere.

Top module: `irqpend_top`

## Requirements
- R1: Synchronous reset clears every pending bit and every software latch, and all outputs read zero while reset is held.
- R2: A write with a 1 in bit b at byte offset 0x200+k, where k runs from 0 to 0x7F, marks source ID 8k+b pending for every processor in that source's target mask from the next cycle on.
- R3: A level-sensitive source (cfg_edge_i bit 0) whose line is high sets pending for its targets in every cycle the line is high. When the line falls, pending is cleared for every processor whose software latch is clear.
- R4: An edge-triggered source (cfg_edge_i bit 1) sets pending for its targets only on a low-to-high transition of its line. A line that stays high does not set it again, and a falling line does not clear it.
- R5: A set-pending write to a level-sensitive source also sets the software latch for its targets. Processors whose latch is set keep pending when the line falls.
- R6: A set-pending write to an edge-triggered source does not set the software latch.
- R7: A write with a 1 in bit b at byte offset 0x280+k affects source ID 8k+b for the writing processor only. It always clears that processor's software latch. It clears that processor's pending bit only if the source is edge-triggered or its line is low.
- R8: Clear-pending writes have no effect on source IDs 0 to 15.
- R9: An acknowledge clears both pending and the software latch of the acknowledged ID. For a source with cfg_any_i bit 1 (one-of-many) this applies to all processors. Otherwise it applies only to the acknowledging processor.
- R10: A write whose computed source ID is NUM_IRQ or above changes no state.
- R11: When any set (register write or hardware line) and any clear act on the same source and processor in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_line_i | input | NUM_IRQ | Hardware request line per source |
| cfg_edge_i | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| cfg_any_i | input | NUM_IRQ | 1 = one-of-many delivery, 0 = one-to-one |
| cfg_target_i | input | NUM_IRQ*NUM_CPU | Target mask; source i at bits [i*NUM_CPU +: NUM_CPU] |
| wr_en_i | input | 1 | Register byte write strobe |
| wr_off_i | input | OFF_W | Byte offset of the write |
| wr_data_i | input | 8 | Write data, one bit per source |
| wr_cpu_i | input | CPU_W | ID of the writing processor |
| ack_en_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | ID_W | Acknowledged source ID |
| ack_cpu_i | input | CPU_W | ID of the acknowledging processor |
| pend_o | output | NUM_CPU*NUM_IRQ | Pending bits; processor c, source i at bit c*NUM_IRQ+i |

## Verification
The scenarios drive a level source through software set, line rise, software clear by one processor and line fall. The outcome then splits by processor, which separates the software latch from the pending bit. An edge source is raised, acknowledged and held high, which shows whether the block reacts to transitions or to levels. A one-of-many source and a one-to-one source are acknowledged in turn to show how far an acknowledge reaches. Further cases cover a clear write into the low ID range, writes above the source count, an edge source whose mode is switched to level after a software set, and a set that coincides with an acknowledge.

// File: rtl/irqpend_pkg.sv
`timescale 1ns/1ps
package irqpend_pkg;
    // Register windows (byte offsets) seen by software
    localparam int SET_BASE  = 32'h200;
    localparam int CLR_BASE  = 32'h280;
    localparam int WIN_BYTES = 32'h80;
    // IDs reserved for software-generated interrupts; clear writes skip them
    localparam int SGI_COUNT = 16;
    localparam int BITS_PER_BYTE = 8;
endpackage

// File: rtl/irqpend_wr_decode.sv
`timescale 1ns/1ps
module irqpend_wr_decode
    import irqpend_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CPU = 8,
    parameter int OFF_W   = 12,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               wr_en_i,
    input  logic [OFF_W-1:0]   wr_off_i,
    input  logic [7:0]         wr_data_i,
    input  logic [CPU_W-1:0]   wr_cpu_i,
    output logic [NUM_IRQ-1:0] set_hit_o,
    output logic [NUM_IRQ-1:0] clr_hit_o,
    output logic [NUM_CPU-1:0] wr_cpu_oh_o
);
    localparam logic [OFF_W-1:0] SET_LO = OFF_W'(SET_BASE);
    localparam logic [OFF_W-1:0] SET_HI = OFF_W'(SET_BASE + WIN_BYTES);
    localparam logic [OFF_W-1:0] CLR_LO = OFF_W'(CLR_BASE);
    localparam logic [OFF_W-1:0] CLR_HI = OFF_W'(CLR_BASE + WIN_BYTES);

    logic             in_set;
    logic             in_clr;
    logic [OFF_W-1:0] set_byte;
    logic [OFF_W-1:0] clr_byte;

    always_comb begin
        in_set   = wr_en_i && (wr_off_i >= SET_LO) && (wr_off_i < SET_HI);
        in_clr   = wr_en_i && (wr_off_i >= CLR_LO) && (wr_off_i < CLR_HI);
        set_byte = wr_off_i - SET_LO;
        clr_byte = wr_off_i - CLR_LO;
    end

    // IDs at or above NUM_IRQ have no decode slot, so such writes vanish
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
        localparam int BYTE_I = i / BITS_PER_BYTE;
        localparam int BIT_I  = i % BITS_PER_BYTE;
        assign set_hit_o[i] = in_set && (set_byte == OFF_W'(BYTE_I)) && wr_data_i[BIT_I];
        if (i < SGI_COUNT) begin : g_sgi
            assign clr_hit_o[i] = 1'b0;
        end else begin : g_spi
            assign clr_hit_o[i] = in_clr && (clr_byte == OFF_W'(BYTE_I)) && wr_data_i[BIT_I];
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign wr_cpu_oh_o[c] = (wr_cpu_i == CPU_W'(c));
    end
endmodule

// File: rtl/irqpend_ack_decode.sv
`timescale 1ns/1ps
module irqpend_ack_decode #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CPU = 8,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               ack_en_i,
    input  logic [ID_W-1:0]    ack_id_i,
    input  logic [CPU_W-1:0]   ack_cpu_i,
    output logic [NUM_IRQ-1:0] ack_hit_o,
    output logic [NUM_CPU-1:0] ack_cpu_oh_o
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
        assign ack_hit_o[i] = ack_en_i && (ack_id_i == ID_W'(i));
    end
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign ack_cpu_oh_o[c] = (ack_cpu_i == CPU_W'(c));
    end
endmodule

// File: rtl/irqpend_cell.sv
`timescale 1ns/1ps
module irqpend_cell #(
    parameter int NUM_CPU = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_i,
    input  logic               edge_mode_i,
    input  logic               any_mode_i,
    input  logic [NUM_CPU-1:0] target_i,
    input  logic               set_wr_i,
    input  logic               clr_wr_i,
    input  logic [NUM_CPU-1:0] wr_cpu_oh_i,
    input  logic               ack_i,
    input  logic [NUM_CPU-1:0] ack_cpu_oh_i,
    output logic [NUM_CPU-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0] pend;
        logic [NUM_CPU-1:0] sw;
        logic               line;
    } cell_state_t;

    cell_state_t state_d, state_q;

    logic               rise, fall, hw_set;
    logic [NUM_CPU-1:0] set_mask, sw_set_mask, ack_mask, clr_wr_mask, pend_clr;

    always_comb begin
        rise   = line_i & ~state_q.line;
        fall   = ~line_i & state_q.line;
        hw_set = edge_mode_i ? rise : line_i;

        set_mask    = (set_wr_i || hw_set) ? target_i : '0;
        sw_set_mask = (set_wr_i && !edge_mode_i) ? target_i : '0;
        ack_mask    = ack_i ? (any_mode_i ? '1 : ack_cpu_oh_i) : '0;
        clr_wr_mask = clr_wr_i ? wr_cpu_oh_i : '0;

        pend_clr = ack_mask;
        if (clr_wr_i && (edge_mode_i || !line_i))
            pend_clr = pend_clr | wr_cpu_oh_i;
        if (fall && !edge_mode_i)
            pend_clr = pend_clr | ~state_q.sw;

        // clears first, sets last: a set in the same cycle wins
        state_d.sw   = (state_q.sw & ~ack_mask & ~clr_wr_mask) | sw_set_mask;
        state_d.pend = (state_q.pend & ~pend_clr) | set_mask;
        state_d.line = line_i;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign pend_o = state_q.pend;
endmodule

// File: rtl/irqpend_top.sv
`timescale 1ns/1ps
module irqpend_top #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CPU = 8,
    parameter int OFF_W   = 12,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_IRQ-1:0]         irq_line_i,
    input  logic [NUM_IRQ-1:0]         cfg_edge_i,
    input  logic [NUM_IRQ-1:0]         cfg_any_i,
    input  logic [NUM_IRQ*NUM_CPU-1:0] cfg_target_i,
    input  logic                       wr_en_i,
    input  logic [OFF_W-1:0]           wr_off_i,
    input  logic [7:0]                 wr_data_i,
    input  logic [CPU_W-1:0]           wr_cpu_i,
    input  logic                       ack_en_i,
    input  logic [ID_W-1:0]            ack_id_i,
    input  logic [CPU_W-1:0]           ack_cpu_i,
    output logic [NUM_CPU*NUM_IRQ-1:0] pend_o
);
    logic [NUM_IRQ-1:0] set_hit, clr_hit, ack_hit;
    logic [NUM_CPU-1:0] wr_cpu_oh, ack_cpu_oh;
    logic [NUM_CPU-1:0] cell_pend [NUM_IRQ];

    irqpend_wr_decode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .OFF_W(OFF_W)) u_wr (
        .wr_en_i     (wr_en_i),
        .wr_off_i    (wr_off_i),
        .wr_data_i   (wr_data_i),
        .wr_cpu_i    (wr_cpu_i),
        .set_hit_o   (set_hit),
        .clr_hit_o   (clr_hit),
        .wr_cpu_oh_o (wr_cpu_oh)
    );

    irqpend_ack_decode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_ack (
        .ack_en_i     (ack_en_i),
        .ack_id_i     (ack_id_i),
        .ack_cpu_i    (ack_cpu_i),
        .ack_hit_o    (ack_hit),
        .ack_cpu_oh_o (ack_cpu_oh)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
        irqpend_cell #(.NUM_CPU(NUM_CPU)) u_cell (
            .clk          (clk),
            .rst          (rst),
            .line_i       (irq_line_i[i]),
            .edge_mode_i  (cfg_edge_i[i]),
            .any_mode_i   (cfg_any_i[i]),
            .target_i     (cfg_target_i[i*NUM_CPU +: NUM_CPU]),
            .set_wr_i     (set_hit[i]),
            .clr_wr_i     (clr_hit[i]),
            .wr_cpu_oh_i  (wr_cpu_oh),
            .ack_i        (ack_hit[i]),
            .ack_cpu_oh_i (ack_cpu_oh),
            .pend_o       (cell_pend[i])
        );
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_map
            assign pend_o[c*NUM_IRQ + i] = cell_pend[i][c];
        end
    end
endmodule

// File: rtl/irqpend_checker.sv
`timescale 1ns/1ps
module irqpend_checker
    import irqpend_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CPU = 8,
    parameter int OFF_W   = 12,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_IRQ-1:0]         irq_line_i,
    input logic [NUM_IRQ-1:0]         cfg_edge_i,
    input logic [NUM_IRQ-1:0]         cfg_any_i,
    input logic [NUM_IRQ*NUM_CPU-1:0] cfg_target_i,
    input logic                       wr_en_i,
    input logic [OFF_W-1:0]           wr_off_i,
    input logic [7:0]                 wr_data_i,
    input logic [CPU_W-1:0]           wr_cpu_i,
    input logic                       ack_en_i,
    input logic [ID_W-1:0]            ack_id_i,
    input logic [CPU_W-1:0]           ack_cpu_i,
    input logic [NUM_CPU*NUM_IRQ-1:0] pend_o
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        localparam logic [OFF_W-1:0] SOFF = OFF_W'(SET_BASE + i / BITS_PER_BYTE);
        localparam logic [OFF_W-1:0] COFF = OFF_W'(CLR_BASE + i / BITS_PER_BYTE);
        localparam int BIT_I = i % BITS_PER_BYTE;

        logic [NUM_CPU-1:0] tgt;
        logic [NUM_CPU-1:0] pv;
        assign tgt = cfg_target_i[i*NUM_CPU +: NUM_CPU];
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_pv
            assign pv[c] = pend_o[c*NUM_IRQ + i];
        end

        AST_SET_WRITE_TARGETS: assert property (@(posedge clk) disable iff (rst)
            (wr_en_i && wr_off_i == SOFF && wr_data_i[BIT_I])
            |=> ((pv & $past(tgt)) == $past(tgt))); // R2

        AST_LEVEL_HIGH_SETS: assert property (@(posedge clk) disable iff (rst)
            (!cfg_edge_i[i] && irq_line_i[i])
            |=> ((pv & $past(tgt)) == $past(tgt))); // R3

        AST_ACK_ONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ack_en_i && ack_id_i == ID_W'(i) && cfg_edge_i[i] && !cfg_any_i[i]
             && !irq_line_i[i] && !wr_en_i)
            |=> !pv[$past(ack_cpu_i)]); // R9

        AST_ACK_ANY_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ack_en_i && ack_id_i == ID_W'(i) && cfg_edge_i[i] && cfg_any_i[i]
             && !irq_line_i[i] && !wr_en_i)
            |=> (pv == '0)); // R9

        if (i < SGI_COUNT) begin : g_sgi
            AST_SGI_CLR_IGNORED: assert property (@(posedge clk) disable iff (rst)
                (wr_en_i && wr_off_i == COFF && wr_data_i[BIT_I] && cfg_edge_i[i]
                 && !ack_en_i && pv[wr_cpu_i])
                |=> pv[$past(wr_cpu_i)]); // R8
        end else begin : g_spi
            AST_EDGE_CLR_WRITE: assert property (@(posedge clk) disable iff (rst)
                (wr_en_i && wr_off_i == COFF && wr_data_i[BIT_I] && cfg_edge_i[i]
                 && !irq_line_i[i])
                |=> !pv[$past(wr_cpu_i)]); // R7
        end
    end
endmodule

bind irqpend_top irqpend_checker #(
    .NUM_IRQ(NUM_IRQ),
    .NUM_CPU(NUM_CPU),
    .OFF_W  (OFF_W)
) u_chk (.*);

// File: tb/tb_irqpend_top.sv
`timescale 1ns/1ps
module tb_irqpend_top;
    localparam int NI = 32;
    localparam int NC = 8;
    localparam int NP = NI * NC;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NI-1:0]   line = '0;
    logic [NI-1:0]   cfg_edge = '0;
    logic [NI-1:0]   cfg_any = '0;
    logic [NI*NC-1:0] tgt = '0;
    logic            wr_en = 1'b0;
    logic [11:0]     wr_off = '0;
    logic [7:0]      wr_data = '0;
    logic [2:0]      wr_cpu = '0;
    logic            ack_en = 1'b0;
    logic [4:0]      ack_id = '0;
    logic [2:0]      ack_cpu = '0;
    logic [NP-1:0]   pend;

    always #10 clk = ~clk; // 50 MHz

    irqpend_top dut (
        .clk(clk), .rst(rst), .irq_line_i(line), .cfg_edge_i(cfg_edge),
        .cfg_any_i(cfg_any), .cfg_target_i(tgt), .wr_en_i(wr_en),
        .wr_off_i(wr_off), .wr_data_i(wr_data), .wr_cpu_i(wr_cpu),
        .ack_en_i(ack_en), .ack_id_i(ack_id), .ack_cpu_i(ack_cpu), .pend_o(pend)
    );

    typedef struct {
        logic [NP-1:0] exp;
        string         req;
    } item_t;

    item_t         sb[$];
    item_t         cur;
    logic [NP-1:0] e = '0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    function automatic int pi(int cpu, int id);
        return cpu * NI + id;
    endfunction

    // monitor: outputs are stable at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            checks++;
            if (pend !== cur.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", cur.req, pend, cur.exp);
            end
        end
    end

    // driver: one clock, then queue what the outputs must show
    task automatic tick(input string req);
        @(posedge clk);
        sb.push_back('{e, req});
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] off, input logic [7:0] d, input logic [2:0] cpu);
        wr_en = 1'b1; wr_off = off; wr_data = d; wr_cpu = cpu;
    endtask

    task automatic ack(input logic [4:0] id, input logic [2:0] cpu);
        ack_en = 1'b1; ack_id = id; ack_cpu = cpu;
    endtask

    task automatic idle();
        wr_en = 1'b0; ack_en = 1'b0;
    endtask

    initial begin
        tgt[20*NC +: NC] = 8'h05;                       // cpu0, cpu2, level
        tgt[17*NC +: NC] = 8'h02; cfg_edge[17] = 1'b1;  // cpu1, edge
        tgt[24*NC +: NC] = 8'hC0; cfg_any[24] = 1'b1;   // cpu6, cpu7, level, one-of-many
        tgt[10*NC +: NC] = 8'h08;                       // cpu3, level
        tgt[3*NC +: NC]  = 8'h01; cfg_edge[3] = 1'b1;   // cpu0, edge, low ID range

        tick("R1 reset held");
        tick("R1 reset held");
        rst = 1'b0;
        tick("R1 after reset");

        // R2 / R5: software set of a level source, line pulse keeps it
        wr(12'h202, 8'h10, 3'd0);
        e[pi(0,20)] = 1'b1; e[pi(2,20)] = 1'b1;
        tick("R2 set write targets");
        idle();
        tick("R2 held");
        line[20] = 1'b1;
        tick("R3 line high");
        line[20] = 1'b0;
        tick("R5 fall keeps sw-set");

        // R7: clear while line high keeps pending but drops the latch of cpu0
        line[20] = 1'b1;
        tick("R3 line high again");
        wr(12'h282, 8'h10, 3'd0);
        tick("R7 clear with line high keeps");
        idle(); line[20] = 1'b0;
        e[pi(0,20)] = 1'b0;
        tick("R7 latch cleared only for writer");
        wr(12'h282, 8'h10, 3'd2);
        e[pi(2,20)] = 1'b0;
        tick("R7 clear with line low");
        idle();

        // R3 / R11: level source, acknowledge while line high
        line[10] = 1'b1;
        e[pi(3,10)] = 1'b1;
        tick("R3 level sets");
        ack(5'd10, 3'd3);
        tick("R11 ack vs level high");
        idle(); line[10] = 1'b0;
        e[pi(3,10)] = 1'b0;
        tick("R3 fall clears");

        // R4: edge source
        line[17] = 1'b1;
        e[pi(1,17)] = 1'b1;
        tick("R4 rising edge");
        ack(5'd17, 3'd1);
        e[pi(1,17)] = 1'b0;
        tick("R9 ack edge");
        idle();
        tick("R4 held high no reset");
        line[17] = 1'b0;
        tick("R4 falling no effect");

        // R9 one-of-many
        wr(12'h203, 8'h01, 3'd5);
        e[pi(6,24)] = 1'b1; e[pi(7,24)] = 1'b1;
        tick("R2 set one-of-many");
        idle(); ack(5'd24, 3'd6);
        e[pi(6,24)] = 1'b0; e[pi(7,24)] = 1'b0;
        tick("R9 one-of-many ack");
        idle(); line[24] = 1'b1;
        e[pi(6,24)] = 1'b1; e[pi(7,24)] = 1'b1;
        tick("R3 level re-sets");
        line[24] = 1'b0;
        e[pi(6,24)] = 1'b0; e[pi(7,24)] = 1'b0;
        tick("R9 latch cleared by ack");

        // R9 one-to-one
        wr(12'h202, 8'h10, 3'd1);
        e[pi(0,20)] = 1'b1; e[pi(2,20)] = 1'b1;
        tick("R2 set again");
        idle(); ack(5'd20, 3'd2);
        e[pi(2,20)] = 1'b0;
        tick("R9 one-to-one ack");
        idle(); wr(12'h282, 8'h10, 3'd0);
        e[pi(0,20)] = 1'b0;
        tick("R7 cleanup clear");
        idle();

        // R8: clear writes ignore IDs below 16
        wr(12'h200, 8'h08, 3'd0);
        e[pi(0,3)] = 1'b1;
        tick("R2 set low ID");
        wr(12'h280, 8'h08, 3'd0);
        tick("R8 clear ignored");
        idle(); ack(5'd3, 3'd0);
        e[pi(0,3)] = 1'b0;
        tick("R9 ack low ID");
        idle();

        // R10: IDs at or above the source count
        wr(12'h204, 8'hFF, 3'd0);
        tick("R10 set beyond count");
        wr(12'h27F, 8'hFF, 3'd0);
        tick("R10 set last byte");
        idle();

        // R6: edge source gets no latch
        wr(12'h202, 8'h02, 3'd0);
        e[pi(1,17)] = 1'b1;
        tick("R2 set edge source");
        idle(); cfg_edge[17] = 1'b0; line[17] = 1'b1;
        tick("R6 level high");
        line[17] = 1'b0;
        e[pi(1,17)] = 1'b0;
        tick("R6 no latch from edge set");
        cfg_edge[17] = 1'b1;

        // R11: set write and acknowledge together
        wr(12'h202, 8'h10, 3'd0); ack(5'd20, 3'd0);
        e[pi(0,20)] = 1'b1; e[pi(2,20)] = 1'b1;
        tick("R11 set beats ack");
        idle();
        tick("R11 held");

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule